// File: doc/BRIEF.md
# End-of-Pipe Fence Writer

This block finishes an end-of-pipe event command once the graphics pipeline has drained. The command fields sit on the inputs. When the drained strobe arrives, the block captures them. It then issues a memory write to a 48-bit byte address, formed from a 32-bit low address and a 16-bit upper part. The write payload is one of five choices:

- no write at all;
- the low immediate word;
- the full 64-bit immediate;
- a free-running 64-bit clock;
- a free-running 64-bit performance counter.

After the write it can raise an interrupt pulse. The pulse comes either straight away, for commands that write nothing, or once memory acknowledges the write.

The memory side is a plain request/acknowledge port. The request stays up with stable fields until the acknowledge. The block accepts a new strobe when no write is outstanding. It also accepts one in the same cycle that the outstanding write is acknowledged, so fences can run back to back. An illegal select combination produces a one-cycle error pulse and no other effect.

Top module: `eop_fence_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_req, irq, err, mem_wide, mem_addr, mem_data, evt_type and evt_index are all zero.
- R2: A drained strobe is accepted when no request is outstanding, or in the cycle that mem_ack completes the outstanding request. A strobe while a request waits without ack is ignored: the request fields stay unchanged and no err or irq results.
- R3: The write address is {data_ctl[15:0], addr_lo}. evt_type takes evt_ctl[5:0] and evt_index takes evt_ctl[11:8] of the accepted command, starting in the cycle after acceptance.
- R4: The data select is data_ctl[31:29]. With value 1 the write carries data_lo zero-extended and mem_wide=0 (4-byte size code). With value 2 it carries {data_hi, data_lo} and mem_wide=1 (8-byte size code).
- R5: Data select 3 writes the clock counter and data select 4 writes the performance counter, both with mem_wide=1. The clock counter equals the number of clock edges since reset was released, counted before the accepting edge. The performance counter equals PERF_STEP times that number.
- R6: mem_req rises in the cycle after acceptance of a writing command. It holds with stable mem_addr, mem_data and mem_wide until a cycle with mem_ack. It then falls, unless a new writing command is accepted in that same cycle.
- R7: Data select 0 issues no memory request.
- R8: Interrupt select data_ctl[25:24] = 2 on a writing command gives a one-cycle irq in the cycle after the ack cycle. Interrupt select 0 gives no irq.
- R9: Data select 0 with interrupt select 1 or 2 gives a one-cycle irq in the cycle after the strobe.
- R10: Data select 5 to 7, interrupt select 3, or interrupt select 1 with a nonzero data select gives a one-cycle err in the cycle after the strobe. Such a command produces no request and no irq.
- R11: When an ack that completes a confirm-mode write meets a new accepted writing strobe in the same cycle, the next cycle shows both the irq pulse and the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drain | input | 1 | Pipeline-drained strobe; the command fields are sampled with it |
| evt_ctl | input | 32 | Event control word: type [5:0], index [11:8] |
| addr_lo | input | 32 | Low 32 bits of the target byte address |
| data_ctl | input | 32 | Upper address [15:0], interrupt select [25:24], data select [31:29] |
| data_lo | input | 32 | Immediate data, low word |
| data_hi | input | 32 | Immediate data, high word |
| mem_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | 48 | Write byte address |
| mem_data | output | 64 | Write payload |
| mem_wide | output | 1 | Size code: 0 = 4 bytes, 1 = 8 bytes |
| mem_ack | input | 1 | Write acknowledge, meaningful while mem_req is high |
| irq | output | 1 | Interrupt pulse |
| err | output | 1 | Illegal-command pulse |
| evt_type | output | 6 | Event type of the last accepted command |
| evt_index | output | 4 | Event index of the last accepted command |

## Verification
The completion of one write and the acceptance of the next can share a cycle. When that happens, the confirm interrupt of the old write must appear together with the rising request of the new one. The same cycle can instead carry an error decision for the new command. The bench forces this overlap directly, by raising mem_ack and a new drained strobe in the same cycle. A long stretch of random strobes and acks then makes it happen again and again. A behavioural model steps through every cycle, and the bench compares irq, err, the request and its fields against the model after each edge.

// File: rtl/eop_fence_writer.sv
module eop_fence_writer #(
  parameter int PERF_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drain,
  input  logic [31:0] evt_ctl,
  input  logic [31:0] addr_lo,
  input  logic [31:0] data_ctl,
  input  logic [31:0] data_lo,
  input  logic [31:0] data_hi,
  output logic        mem_req,
  output logic [47:0] mem_addr,
  output logic [63:0] mem_data,
  output logic        mem_wide,
  input  logic        mem_ack,
  output logic        irq,
  output logic        err,
  output logic [5:0]  evt_type,
  output logic [3:0]  evt_index
);

  localparam logic [2:0] SEL_NONE = 3'd0;
  localparam logic [2:0] SEL_LO32 = 3'd1;
  localparam logic [2:0] SEL_IMM64 = 3'd2;
  localparam logic [2:0] SEL_CLK = 3'd3;
  localparam logic [2:0] SEL_PERF = 3'd4;
  localparam logic [1:0] IRQ_NOW = 2'd1;
  localparam logic [1:0] IRQ_ACK = 2'd2;
  localparam logic [1:0] IRQ_BAD = 2'd3;
  localparam logic [63:0] PSTEP = 64'(PERF_STEP);

  logic [63:0] clk_cnt, perf_cnt;
  logic        confirm_q;

  wire [2:0] dsel = data_ctl[31:29];
  wire [1:0] isel = data_ctl[25:24];

  wire done   = mem_req && mem_ack;
  wire accept = drain && (!mem_req || mem_ack);
  wire bad    = (dsel > SEL_PERF) || (isel == IRQ_BAD) ||
                (isel == IRQ_NOW && dsel != SEL_NONE);
  wire writes = !bad && dsel != SEL_NONE;
  wire quick  = !bad && dsel == SEL_NONE && isel != 2'd0;

  logic [63:0] payload;
  always_comb begin
    case (dsel)
      SEL_LO32:  payload = {32'h0, data_lo};
      SEL_IMM64: payload = {data_hi, data_lo};
      SEL_CLK:   payload = clk_cnt;
      default:   payload = perf_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt   <= '0;
      perf_cnt  <= '0;
      confirm_q <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_wide  <= 1'b0;
      irq       <= 1'b0;
      err       <= 1'b0;
      evt_type  <= '0;
      evt_index <= '0;
    end else begin
      clk_cnt  <= clk_cnt + 64'd1;
      perf_cnt <= perf_cnt + PSTEP;
      irq      <= (accept && quick) || (done && confirm_q);
      err      <= accept && bad;
      if (done) mem_req <= 1'b0;
      if (accept) begin
        evt_type  <= evt_ctl[5:0];
        evt_index <= evt_ctl[11:8];
        if (writes) begin
          mem_req   <= 1'b1;
          mem_addr  <= {data_ctl[15:0], addr_lo};
          mem_data  <= payload;
          mem_wide  <= dsel != SEL_LO32;
          confirm_q <= isel == IRQ_ACK;
        end
      end
    end
  end

endmodule

// File: rtl/eop_fence_checker.sv
module eop_fence_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        drain,
  input logic        mem_req,
  input logic [47:0] mem_addr,
  input logic [63:0] mem_data,
  input logic        mem_wide,
  input logic        mem_ack,
  input logic        irq,
  input logic        err
);

  // R6: an unacknowledged request keeps its fields
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_wide));

  // R10: an error never starts a write
  a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$rose(mem_req));

  // R10: an error follows a strobe
  a_r10_err_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(drain));

  // R8: an irq not caused by a strobe comes from a completed write
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !$past(drain) |-> $past(mem_req && mem_ack));

  // R4: a narrow write carries a zero upper word
  a_r4_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_wide |-> mem_data[63:32] == 32'h0);

endmodule

bind eop_fence_writer eop_fence_checker u_chk (
  .clk(clk), .rst_n(rst_n), .drain(drain), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_wide(mem_wide),
  .mem_ack(mem_ack), .irq(irq), .err(err)
);

// File: tb/tb_eop_fence_writer.sv
module tb_eop_fence_writer;
  localparam int STEP = 4;

  logic clk = 0, rst_n = 0, drain = 0, mem_ack = 0;
  logic [31:0] evt_ctl = 0, addr_lo = 0, data_ctl = 0, data_lo = 0, data_hi = 0;
  logic mem_req, mem_wide, irq, err;
  logic [47:0] mem_addr;
  logic [63:0] mem_data;
  logic [5:0] evt_type;
  logic [3:0] evt_index;

  eop_fence_writer #(.PERF_STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .drain(drain), .evt_ctl(evt_ctl), .addr_lo(addr_lo),
    .data_ctl(data_ctl), .data_lo(data_lo), .data_hi(data_hi), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_wide(mem_wide), .mem_ack(mem_ack),
    .irq(irq), .err(err), .evt_type(evt_type), .evt_index(evt_index));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] m_cyc = 0, m_data = 0;
  logic [47:0] m_addr = 0;
  logic m_req = 0, m_wide = 0, m_irq = 0, m_err = 0, m_conf = 0;
  logic [5:0] m_type = 0;
  logic [3:0] m_idx = 0;
  int m_ds = 0;
  string irq_tag = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_req = 0; m_wide = 0; m_irq = 0; m_err = 0; m_conf = 0;
      m_addr = 0; m_data = 0; m_type = 0; m_idx = 0;
    end else begin
      int ds, is;
      bit take, legal;
      ds = int'(data_ctl[31:29]);
      is = int'(data_ctl[25:24]);
      take = drain && (!m_req || mem_ack);
      m_irq = 0; m_err = 0;
      if (m_req && mem_ack) begin
        m_req = 0;
        if (m_conf) begin m_irq = 1; irq_tag = "R8"; end
      end
      if (take) begin
        legal = (ds <= 4) && (is != 3) && !(is == 1 && ds != 0);
        m_type = evt_ctl[5:0];
        m_idx = evt_ctl[11:8];
        if (!legal) m_err = 1;
        else if (ds == 0) begin
          if (is != 0) begin m_irq = 1; irq_tag = "R9"; end
        end else begin
          m_req = 1; m_ds = ds; m_conf = (is == 2);
          m_addr = {data_ctl[15:0], addr_lo};
          m_wide = (ds != 1);
          case (ds)
            1: m_data = {32'h0, data_lo};
            2: m_data = {data_hi, data_lo};
            3: m_data = m_cyc;
            default: m_data = m_cyc * STEP;
          endcase
        end
      end
      m_cyc = m_cyc + 1;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R10 err", err, m_err);
    chk({irq_tag, " irq"}, irq, m_irq);
    chk("R6 mem_req", mem_req, m_req);
    chk("R3 evt", {evt_type, evt_index}, {m_type, m_idx});
    if (m_req) begin
      chk("R3 addr", mem_addr, m_addr);
      chk("R4 size", mem_wide, m_wide);
      chk(m_ds >= 3 ? "R5 data" : "R4 data", mem_data, m_data);
    end
  end

  task automatic send(input logic [2:0] ds, input logic [1:0] is, input logic [31:0] lo,
                      input logic [31:0] hi, input logic [47:0] a, input logic ack);
    drain = 1; mem_ack = ack;
    data_ctl = {ds, 3'b0, is, 8'h0, a[47:32]};
    addr_lo = a[31:0]; data_lo = lo; data_hi = hi;
    evt_ctl = {20'h0, 4'(ds + 3'd5), 2'b0, 6'(lo[5:0])};
    @(negedge clk);
    drain = 0; mem_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {mem_req, irq, err, mem_wide, mem_addr, mem_data, evt_type, evt_index}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {mem_req, irq, err, mem_data}, '0);
    send(3'd1, 2'd2, 32'hDEAD0001, 32'h1111, 48'h1234_0000_0040, 0);
    chk("R4 narrow", {mem_req, mem_wide}, 2'b10);
    repeat (2) @(negedge clk);
    mem_ack = 1; @(negedge clk); mem_ack = 0;
    chk("R8 confirm irq", irq, 1);
    send(3'd2, 2'd0, 32'hA5A5, 32'h5A5A, 48'hBEEF_1000_0000, 0);
    send(3'd1, 2'd0, 32'h77, 32'h0, 48'h1, 0);
    chk("R2 ignored strobe addr", mem_addr, 48'hBEEF_1000_0000);
    chk("R2 ignored strobe err", err, 0);
    mem_ack = 1; @(negedge clk); mem_ack = 0;
    chk("R8 no irq", irq, 0);
    send(3'd0, 2'd0, 32'h3, 32'h0, 48'h0, 0);
    chk("R7 no write", mem_req, 0);
    send(3'd0, 2'd1, 32'h4, 32'h0, 48'h0, 0);
    chk("R9 immediate irq", irq, 1);
    send(3'd5, 2'd0, 32'h5, 32'h0, 48'h0, 0);
    chk("R10 bad select", {err, mem_req}, 2'b10);
    send(3'd2, 2'd1, 32'h6, 32'h0, 48'h0, 0);
    chk("R10 irq-only with write", {err, mem_req, irq}, 3'b100);
    send(3'd3, 2'd2, 32'h7, 32'h0, 48'h8, 0);
    chk("R5 clock wide", mem_wide, 1);
    send(3'd4, 2'd0, 32'h8, 32'h0, 48'h10, 1);
    chk("R11 irq with new request", {irq, mem_req}, 2'b11);
    mem_ack = 1; @(negedge clk); mem_ack = 0;
    for (int i = 0; i < 2000; i++) begin
      drain = ($urandom % 3) == 0;
      mem_ack = $urandom % 2;
      data_ctl = $urandom;
      data_ctl[31:29] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
      data_ctl[25:24] = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd2;
      addr_lo = $urandom; data_lo = $urandom; data_hi = $urandom; evt_ctl = $urandom;
      @(negedge clk);
    end
    drain = 0; mem_ack = 1;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule